// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block keeps a short, byte-wide store of upcoming instruction bytes so that memory fetching runs ahead of the consumer that uses them. It holds a code segment value and an instruction pointer. From these it forms a 20-bit physical fetch address and issues 16-bit reads on a request/acknowledge memory port. The returned bytes are pushed into a first-in-first-out store that can hold up to six bytes.

An execution stage drains the store one byte at a time through a valid/ready handshake, independently of the fetch side. A byte can be pushed and a byte popped in the same cycle. When control flow changes, a flush input supplies a new segment and pointer. The store is then emptied at once, fetching restarts at the new location, and the data of any read still in flight is thrown away when it returns.

Top module: `prefetch_queue`

## Requirements
- R1: While rst_n is low, mem_req and q_valid are 0. After reset is released, fetching starts at segment 0x0000, offset 0x0000.
- R2: Every fetch address equals the 16-bit segment shifted left by 4 bits plus the 16-bit offset, as a 20-bit value.
- R3: The store never holds more than 6 bytes. A word read is issued only when at least 2 entries are free, and a byte read only when at least 1 entry is free. Fetching therefore continues while the consumer is stalled. With a stalled consumer, a stream that starts at an even offset settles at 6 held bytes, and one that starts at an odd offset settles at 5.
- R4: At an odd address the block issues a byte read (mem_word=0) and takes the byte from mem_rdata[15:8]. At an even address it issues a word read (mem_word=1).
- R5: For a word read, mem_rdata[7:0] is pushed before mem_rdata[15:8]. The offset advances by the number of bytes pushed, so the consumer receives the bytes of consecutive offsets in order.
- R6: Once mem_req is raised, it stays high with mem_addr and mem_word unchanged until the cycle in which mem_ack is high. At most one read is outstanding.
- R7: q_valid is high exactly when the store is not empty, and it stays high until the byte is taken with q_ready. A pop and a push may happen in the same cycle.
- R8: A flush empties the store, so q_valid is 0 in the following cycle. It loads the new segment and offset, and it discards the data of a read that is outstanding or that is acknowledged in the flush cycle. A pop during a flush cycle is ignored.
- R9: The offset wraps modulo 2^16 and the address sum wraps modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Restart prefetching at flush_seg:flush_ofs |
| flush_seg | input | 16 | New code segment value |
| flush_ofs | input | 16 | New instruction offset |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 20 | Physical read address |
| mem_word | output | 1 | 1 = 16-bit read, 0 = single byte from upper lane |
| mem_ack | input | 1 | Read data valid, one-cycle pulse |
| mem_rdata | input | 16 | Read data |
| q_valid | output | 1 | A byte is available to the consumer |
| q_data | output | 8 | Oldest byte in the store |
| q_ready | input | 1 | Consumer takes the byte |

## Verification
A read request appears one cycle after the cycle in which the room condition holds. Returned bytes become visible on q_valid/q_data one cycle after the edge that samples mem_ack. A flush shows as q_valid low at the first falling edge after the flush edge. The bench drives all inputs 1 ns after a rising edge, and its memory model acts 2 ns after the edge. The scoreboard monitor samples the handshake at the falling edge, which is the state the next rising edge acts on. Because of this, every comparison happens at the cycle in which the result is due, with no dependence on process order.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic {
    FETCH_IDLE = 1'b0,
    FETCH_BUSY = 1'b1
  } fetch_state_e;
endpackage

// File: rtl/pfq_fetch_ptr.sv
module pfq_fetch_ptr #(
  parameter int SEG_W   = 16,
  parameter int OFS_W   = 16,
  parameter int SHIFT   = 4,
  parameter int ADDR_W  = 20,
  parameter int PUSH_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SEG_W-1:0]  load_seg,
  input  logic [OFS_W-1:0]  load_ofs,
  input  logic [PUSH_W-1:0] advance,
  output logic [ADDR_W-1:0] phys_addr
);
  logic [SEG_W-1:0] seg_q, seg_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = load || (advance != '0);
    seg_d  = seg_q;
    ofs_d  = ofs_q;
    if (load) begin
      seg_d = load_seg;
      ofs_d = load_ofs;
    end else begin
      ofs_d = ofs_q + OFS_W'(advance);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
      ofs_q <= '0;
    end else if (ptr_en) begin
      seg_q <= seg_d;
      ofs_q <= ofs_d;
    end
  end

  // base shifted by SHIFT bits, offset zero-extended, sum truncated
  assign phys_addr = ADDR_W'({seg_q, {SHIFT{1'b0}}}) + ADDR_W'(ofs_q);
endmodule

// File: rtl/pfq_fetch_ctrl.sv
module pfq_fetch_ctrl
  import pfq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 3,
  parameter int PUSH_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [CNT_W-1:0]  free_cnt,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_word,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata,
  output logic [PUSH_W-1:0] push_n,
  output logic [7:0]        push_d0,
  output logic [7:0]        push_d1
);
  fetch_state_e      state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              word_q, word_d;
  logic              drop_q, drop_d;
  logic              room_ok;
  logic              want_word;
  logic              ack_take;

  always_comb begin
    want_word = ~cur_addr[0];
    room_ok   = want_word ? (free_cnt >= CNT_W'(2)) : (free_cnt >= CNT_W'(1));
  end

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    word_d  = word_q;
    drop_d  = drop_q;
    case (state_q)
      FETCH_IDLE: begin
        drop_d = 1'b0;
        if (!flush && room_ok) begin
          state_d = FETCH_BUSY;
          addr_d  = cur_addr;
          word_d  = want_word;
        end
      end
      FETCH_BUSY: begin
        if (mem_ack) begin
          state_d = FETCH_IDLE;
          drop_d  = 1'b0;
        end else if (flush) begin
          drop_d  = 1'b1;
        end
      end
      default: state_d = FETCH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FETCH_IDLE;
      addr_q  <= '0;
      word_q  <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      drop_q  <= drop_d;
      if (state_q == FETCH_IDLE) begin
        addr_q <= addr_d;
        word_q <= word_d;
      end
    end
  end

  always_comb begin
    ack_take = (state_q == FETCH_BUSY) && mem_ack && !drop_q && !flush;
    push_n   = '0;
    push_d0  = word_q ? mem_rdata[7:0] : mem_rdata[15:8];
    push_d1  = mem_rdata[15:8];
    if (ack_take) push_n = word_q ? PUSH_W'(2) : PUSH_W'(1);
  end

  assign mem_req  = (state_q == FETCH_BUSY);
  assign mem_addr = addr_q;
  assign mem_word = word_q;
endmodule

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo #(
  parameter int DEPTH  = 6,
  parameter int DW     = 8,
  parameter int PUSH_W = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [PUSH_W-1:0] push_n,
  input  logic [DW-1:0]     push_d0,
  input  logic [DW-1:0]     push_d1,
  input  logic              pop_req,
  output logic              not_empty,
  output logic [DW-1:0]     head,
  output logic [CNT_W-1:0]  fill
);
  logic [DW-1:0]    slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, wr_p1;
  logic [PTR_W-1:0] rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_pop;
  logic             we0, we1;
  logic             ptr_en;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    do_pop = pop_req && (cnt_q != '0) && !clear;
    we0    = (push_n != '0) && !clear;
    we1    = (push_n == PUSH_W'(2)) && !clear;
    wr_p1  = ptr_inc(wr_q);
    ptr_en = clear || we0 || do_pop;
    if (clear) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      wr_d  = we1 ? ptr_inc(wr_p1) : (we0 ? wr_p1 : wr_q);
      rd_d  = do_pop ? ptr_inc(rd_q) : rd_q;
      cnt_d = cnt_q + CNT_W'(push_n) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (ptr_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic sel0, sel1;
    assign sel0 = we0 && (wr_q  == PTR_W'(gi));
    assign sel1 = we1 && (wr_p1 == PTR_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    slot_q[gi] <= '0;
      else if (sel0) slot_q[gi] <= push_d0;
      else if (sel1) slot_q[gi] <= push_d1;
    end
  end

  assign not_empty = (cnt_q != '0);
  assign head      = slot_q[rd_q];
  assign fill      = cnt_q;
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int DEPTH  = 6,
  parameter int SEG_W  = 16,
  parameter int OFS_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [SEG_W-1:0]  flush_seg,
  input  logic [OFS_W-1:0]  flush_ofs,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_word,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata,
  output logic              q_valid,
  output logic [7:0]        q_data,
  input  logic              q_ready
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int PUSH_W = 2;

  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  q_fill;
  logic [CNT_W-1:0]  free_cnt;
  logic [PUSH_W-1:0] push_n;
  logic [7:0]        push_d0, push_d1;

  assign free_cnt = CNT_W'(DEPTH) - q_fill;

  pfq_fetch_ptr #(
    .SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W), .PUSH_W(PUSH_W)
  ) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (flush),
    .load_seg  (flush_seg),
    .load_ofs  (flush_ofs),
    .advance   (push_n),
    .phys_addr (cur_addr)
  );

  pfq_fetch_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PUSH_W(PUSH_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .cur_addr  (cur_addr),
    .free_cnt  (free_cnt),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_word  (mem_word),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .push_n    (push_n),
    .push_d0   (push_d0),
    .push_d1   (push_d1)
  );

  pfq_byte_fifo #(
    .DEPTH(DEPTH), .DW(8), .PUSH_W(PUSH_W)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flush),
    .push_n    (push_n),
    .push_d0   (push_d0),
    .push_d1   (push_d1),
    .pop_req   (q_ready),
    .not_empty (q_valid),
    .head      (q_data),
    .fill      (q_fill)
  );
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int DEPTH  = 6,
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_word,
  input logic              q_valid,
  input logic              q_ready,
  input logic [CNT_W-1:0]  fill
);
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_word));

  a_r4_word_even: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_word |-> !mem_addr[0]);

  a_r4_odd_byte: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_addr[0] |-> !mem_word);

  a_r3_word_room: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_word |-> fill <= CNT_W'(DEPTH - 2));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !q_valid);

  a_r7_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && !q_ready && !flush |=> q_valid);
endmodule

bind prefetch_queue pfq_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flush    (flush),
  .mem_req  (mem_req),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .mem_word (mem_word),
  .q_valid  (q_valid),
  .q_ready  (q_ready),
  .fill     (q_fill)
);

// File: tb/prefetch_queue_tb.sv
`timescale 1ns/1ps
module prefetch_queue_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [15:0] flush_seg = '0;
  logic [15:0] flush_ofs = '0;
  logic        mem_req;
  logic [19:0] mem_addr;
  logic        mem_word;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        q_valid;
  logic [7:0]  q_data;
  logic        q_ready = 1'b0;

  always #4 clk = ~clk;

  prefetch_queue u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_seg(flush_seg),
    .flush_ofs(flush_ofs), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_word(mem_word), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .q_valid(q_valid), .q_data(q_data), .q_ready(q_ready)
  );

  int checks = 0;
  int fails  = 0;
  int pops   = 0;
  logic [7:0] exp_q[$];

  int          lat = 0;
  bit          hold = 1'b0;
  int          lat_cnt = 0;
  bit          first_pend = 1'b0;
  logic [19:0] first_addr = '0;

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  function automatic logic [7:0] mbyte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // driver side of the scoreboard: expected byte stream for a start point
  task automatic expect_stream(input logic [15:0] s, input logic [15:0] o);
    exp_q.delete();
    for (int i = 0; i < 512; i++) exp_q.push_back(mbyte(phys(s, o + 16'(i))));
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_flush(input logic [15:0] s, input logic [15:0] o);
    @(posedge clk); #1;
    flush = 1'b1; flush_seg = s; flush_ofs = o;
    expect_stream(s, o);
    @(posedge clk); #1;
    flush = 1'b0;
    first_pend = 1'b1;
    first_addr = phys(s, o);
    @(negedge clk);
    chk(!q_valid, "R8 q_valid after flush", q_valid, 0);
    @(posedge clk); #1;
  endtask

  // memory model, acts 2 ns after each rising edge
  initial begin
    logic        prev_req = 1'b0;
    logic [19:0] prev_addr = '0;
    logic        prev_word = 1'b0;
    forever begin
      @(posedge clk); #2;
      if (!rst_n) begin
        mem_ack = 1'b0; prev_req = 1'b0; lat_cnt = 0;
      end else begin
        if (mem_req && !prev_req) begin
          chk(mem_word == ~mem_addr[0], "R4 read size vs address parity", mem_word, ~mem_addr[0]);
          if (first_pend) begin
            chk(mem_addr == first_addr, "R2 R9 first fetch address", mem_addr, first_addr);
            first_pend = 1'b0;
          end
        end else if (mem_req && prev_req) begin
          chk(mem_addr == prev_addr && mem_word == prev_word, "R6 request held",
              mem_addr, prev_addr);
        end
        prev_req = mem_req; prev_addr = mem_addr; prev_word = mem_word;
        if (mem_ack) begin
          mem_ack = 1'b0; lat_cnt = 0;
        end else if (mem_req && !hold) begin
          if (lat_cnt >= lat) begin
            mem_ack = 1'b1;
            mem_rdata = mem_word ? {mbyte(mem_addr + 20'd1), mbyte(mem_addr)}
                                 : {mbyte(mem_addr), 8'hEE};
          end else lat_cnt++;
        end
      end
    end
  end

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !flush && q_valid && q_ready) begin
        pops++;
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected byte", q_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(q_data == e, "R5 R9 byte order", q_data, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int p0;
    expect_stream(16'h0000, 16'h0000);
    first_pend = 1'b1; first_addr = 20'h0;
    repeat (3) @(negedge clk);
    chk(!mem_req && !q_valid, "R1 reset outputs", {mem_req, q_valid}, 0);
    @(posedge clk); #1; rst_n = 1'b1;

    // free run from reset origin, pops overlap with pushes (R7)
    q_ready = 1'b1; lat = 0;
    step(120);

    // stall with even start: settles at 6 bytes (R3)
    q_ready = 1'b0;
    do_flush(16'h0100, 16'h0020);
    step(40);
    chk(!mem_req, "R3 no request when full", mem_req, 0);
    chk(q_valid, "R7 valid held while stalled", q_valid, 1);
    hold = 1'b1; p0 = pops; q_ready = 1'b1;
    step(20);
    chk(pops - p0 == 6, "R3 even start holds 6", pops - p0, 6);
    chk(!q_valid, "R7 valid low when empty", q_valid, 0);
    hold = 1'b0;

    // stall with odd start: settles at 5 bytes (R3, R4)
    q_ready = 1'b0;
    do_flush(16'h1234, 16'h0011);
    step(40);
    hold = 1'b1; p0 = pops; q_ready = 1'b1;
    step(20);
    chk(pops - p0 == 5, "R3 odd start holds 5", pops - p0, 5);
    hold = 1'b0;
    step(30);

    // flush during an outstanding read discards its data (R8)
    lat = 8;
    do_flush(16'h2000, 16'h0004);
    step(2);
    chk(mem_req, "R8 read outstanding before second flush", mem_req, 1);
    do_flush(16'h3000, 16'h0103);
    lat = 1;
    step(80);

    // consumer toggling q_ready
    lat = 2;
    do_flush(16'h4A5B, 16'h7FFE);
    for (int i = 0; i < 80; i++) begin q_ready = i[0]; step(1); end
    q_ready = 1'b1;

    // address sum wrap and offset wrap (R9)
    lat = 0;
    do_flush(16'hFFFF, 16'hFFF0);
    step(40);
    do_flush(16'hFFFF, 16'hFFFD);
    step(40);
    do_flush(16'h0000, 16'hFFFF);
    step(40);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule